// File: doc/BRIEF.md
# Programmable 8-bit PWM Channel with Timer Access

The block makes one pulse-width-modulated output from a clock-enable strobe supplied by an external prescaler. A reloadable rate divider passes one tick out of every N+1 strobes. Each tick advances a free-running 8-bit pulse counter. The output goes high when that counter wraps to zero and goes low when the counter reaches a programmed compare value, so the compare value sets the duty cycle and N sets the period.

Software reaches the channel through three register ports, each with its own write strobe and a read path that is always live: a control register, the divider's reload register and a shared data register. A select bit in the control register points the data register at either the compare value or the live pulse counter. This lets software preload the counter or use it as a plain timer. Further control bits enable the divider, gate the output, force the output high for a steady DC level, and hold a rollover flag that hardware sets and software clears.

Top module: `pwm_channel`

## Requirements
- R1: The rate divider emits one tick per N+1 strobes on `pre_tick`, where N is the reload register read on `rate_rdata`. N=0 gives a tick on every strobe and N=255 gives one tick per 256 strobes. While the divider is disabled, its count is reloaded from N.
- R2: The divider advances only while control bit 4 (rate enable) is 1. While it is 0, the pulse counter does not move.
- R3: `pwm_out` is 0 whenever control bit 2 (output enable) is 0.
- R4: On a tick that takes the pulse counter from 0xFF to 0x00, the internal output is set to 1, provided the compare value is nonzero.
- R5: On a tick that brings the pulse counter equal to the nonzero compare value, the output is cleared to 0.
- R6: While the compare value is 0, the output stays at 0, including in the cycle of the wrap.
- R7: When control bit 1 (DC mode) is 1 and output enable is 1, `pwm_out` is 1 whatever the counter and compare values are.
- R8: Control bit 0 (select) decides what the data port reaches. At 0, writes and reads on the data port reach the compare register. At 1, they reach the live pulse counter.
- R9: Control bit 3 is a rollover flag that is set on each 0xFF-to-0x00 wrap. A control write with bit 3 at 0 clears it. A control write with bit 3 at 1 leaves it unchanged.
- R10: If a wrap and a clearing control write fall in the same cycle, the flag ends up set.
- R11: A counter write through the data port takes effect that cycle and overrides a tick that arrives in the same cycle. Such a write never counts as a wrap.
- R12: After reset, every register reads 0 and `pwm_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pre_tick | input | 1 | Prescaler strobe, one cycle wide per prescaled tick |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control write value: bit 0 select, bit 1 DC mode, bit 2 output enable, bit 3 flag, bit 4 rate enable |
| ctl_rdata | output | 5 | Control register contents, including the flag |
| rate_we | input | 1 | Reload register write strobe |
| rate_wdata | input | 8 | Reload value N |
| rate_rdata | output | 8 | Current reload value |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Value for the compare register or the counter |
| dat_rdata | output | 8 | Compare register or live counter, chosen by select |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions check five behaviours on every cycle: the divider reloads after each tick, a counter write wins over a tick, a zero compare forces the output low, a wrap with a nonzero compare sets the output, and the flag is sticky with a set that wins over a clear. Some behaviours depend on how long a sequence of strobes runs, and only the bench scenarios can show them. These are the exact N+1 tick spacing at N=0, N=3 and N=255, the high time of the output in relation to the compare value, gating by the output enable and DC mode, and the way the select bit steers reads and writes.

// File: rtl/pwm_ch_pkg.sv
package pwm_ch_pkg;

    parameter int unsigned CTL_W    = 5;
    parameter int unsigned BIT_SEL  = 0;
    parameter int unsigned BIT_DC   = 1;
    parameter int unsigned BIT_OE   = 2;
    parameter int unsigned BIT_FLAG = 3;
    parameter int unsigned BIT_EN   = 4;

    // Packed MSB first: en is bit 4, sel is bit 0.
    typedef struct packed {
        logic en;
        logic flag;
        logic oe;
        logic dc;
        logic sel;
    } ctl_t;

endpackage

// File: rtl/pwm_rate_div.sv
module pwm_rate_div #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         pre_i,
    input  logic [W-1:0] reload_i,
    output logic         tick_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        tick_o = en_i && pre_i && (cnt_q == '0);
        if (!en_i) begin
            cnt_d = reload_i;
        end else if (pre_i) begin
            if (cnt_q == '0) cnt_d = reload_i;
            else             cnt_d = cnt_q - {{(W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1: after a tick the count restarts from the reload value
    p_reload_after_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (cnt_q == $past(reload_i)));

endmodule

// File: rtl/pwm_pulse_gen.sv
module pwm_pulse_gen #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic [W-1:0] cmp_i,
    output logic [W-1:0] cnt_o,
    output logic         out_o,
    output logic         wrap_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         out;
    } pulse_t;

    pulse_t st_d, st_q;
    logic   adv;

    always_comb begin
        st_d   = st_q;
        adv    = tick_i && !load_i;
        wrap_o = adv && (st_q.cnt == '1);
        if (load_i)   st_d.cnt = load_val_i;
        else if (adv) st_d.cnt = st_q.cnt + {{(W-1){1'b0}}, 1'b1};

        if (cmp_i == '0)                       st_d.out = 1'b0;
        else if (wrap_o)                       st_d.out = 1'b1;
        else if (adv && (st_d.cnt == cmp_i))   st_d.out = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign out_o = st_q.out;

    // R11: a port write lands in the counter regardless of any tick
    p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.cnt == $past(load_val_i)));

    // R6: zero compare keeps the output low
    p_zero_cmp_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_i == '0) |=> !st_q.out);

    // R4: wrap with nonzero compare raises the output
    p_wrap_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && cmp_i != '0) |=> st_q.out);

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_ch_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_tick,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic             rate_we,
    input  logic [W-1:0]     rate_wdata,
    output logic [W-1:0]     rate_rdata,
    input  logic             dat_we,
    input  logic [W-1:0]     dat_wdata,
    output logic [W-1:0]     dat_rdata,
    output logic             pwm_out
);

    typedef struct packed {
        ctl_t         ctl;
        logic [W-1:0] rate;
        logic [W-1:0] cmp;
    } regs_t;

    regs_t        r_d, r_q;
    logic         tick, wrap, cnt_load, pulse_out;
    logic [W-1:0] cnt;

    always_comb begin
        r_d      = r_q;
        cnt_load = dat_we && r_q.ctl.sel;
        if (ctl_we) begin
            r_d.ctl      = ctl_t'(ctl_wdata);
            r_d.ctl.flag = r_q.ctl.flag && ctl_wdata[BIT_FLAG];
        end
        if (wrap)                    r_d.ctl.flag = 1'b1;
        if (rate_we)                 r_d.rate     = rate_wdata;
        if (dat_we && !r_q.ctl.sel)  r_d.cmp      = dat_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    pwm_rate_div #(.W(W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (r_q.ctl.en),
        .pre_i    (pre_tick),
        .reload_i (r_q.rate),
        .tick_o   (tick)
    );

    pwm_pulse_gen #(.W(W)) u_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .load_i     (cnt_load),
        .load_val_i (dat_wdata),
        .cmp_i      (r_q.cmp),
        .cnt_o      (cnt),
        .out_o      (pulse_out),
        .wrap_o     (wrap)
    );

    assign ctl_rdata  = r_q.ctl;
    assign rate_rdata = r_q.rate;
    assign dat_rdata  = r_q.ctl.sel ? cnt : r_q.cmp;
    assign pwm_out    = r_q.ctl.oe && (r_q.ctl.dc || pulse_out);

    // R10: a wrap always leaves the flag set, even against a clear
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> r_q.ctl.flag);

    // R9: without a clearing write the flag holds
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ctl.flag && !(ctl_we && !ctl_wdata[BIT_FLAG])) |=> r_q.ctl.flag);

endmodule

// File: tb/sim_pwm_channel.sv
module sim_pwm_channel;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pre_tick = 1'b0;
    logic       ctl_we = 1'b0;
    logic [4:0] ctl_wdata = '0;
    logic [4:0] ctl_rdata;
    logic       rate_we = 1'b0;
    logic [7:0] rate_wdata = '0;
    logic [7:0] rate_rdata;
    logic       dat_we = 1'b0;
    logic [7:0] dat_wdata = '0;
    logic [7:0] dat_rdata;
    logic       pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    port;   // 0 pwm_out, 1 dat_rdata, 2 ctl_rdata, 3 rate_rdata
        int    exp;
        string req;
    } item_t;

    item_t q[$];
    event  chk_ev;

    always #10 clk = ~clk;

    pwm_channel u0 (
        .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .rate_we(rate_we), .rate_wdata(rate_wdata), .rate_rdata(rate_rdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .pwm_out(pwm_out)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                int act;
                it = q.pop_front();
                case (it.port)
                    0:       act = int'(pwm_out);
                    1:       act = int'(dat_rdata);
                    2:       act = int'(ctl_rdata);
                    default: act = int'(rate_rdata);
                endcase
                checks++;
                if (act != it.exp) begin
                    errors++;
                    $display("FAIL %s port%0d actual=%0h expected=%0h", it.req, it.port, act, it.exp);
                end
            end
        end
    end

    task automatic expect_port(input int port, input int exp, input string req);
        item_t it;
        it.port = port; it.exp = exp; it.req = req;
        q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    task automatic ctl_write(input logic [4:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic rate_write(input logic [7:0] v);
        rate_we = 1'b1; rate_wdata = v;
        @(negedge clk);
        rate_we = 1'b0;
    endtask

    task automatic dat_write(input logic [7:0] v);
        dat_we = 1'b1; dat_wdata = v;
        @(negedge clk);
        dat_we = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            pre_tick = 1'b1;
            @(negedge clk);
        end
        pre_tick = 1'b0;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        expect_port(0, 0, "R12");
        expect_port(2, 0, "R12");
        expect_port(1, 0, "R12");
        expect_port(3, 0, "R12");

        // R1 divide by 4
        rate_write(8'd3);
        expect_port(3, 3, "R1");
        ctl_write(5'h11);
        pulse(8);  expect_port(1, 2, "R1");
        pulse(3);  expect_port(1, 2, "R1");
        pulse(1);  expect_port(1, 3, "R1");

        // R2 disabled divider holds the counter
        ctl_write(5'h01);
        pulse(10); expect_port(1, 3, "R2");

        // R1 N=0 passes every strobe
        rate_write(8'd0);
        ctl_write(5'h11);
        pulse(5);  expect_port(1, 8, "R1");

        // R1 N=255 divides by 256
        rate_write(8'hFF);
        ctl_write(5'h01);
        ctl_write(5'h11);
        pulse(255); expect_port(1, 8, "R1");
        pulse(1);   expect_port(1, 9, "R1");
        rate_write(8'd0);
        ctl_write(5'h01);
        ctl_write(5'h11);

        // R8 counter load, R9 flag
        dat_write(8'hFD); expect_port(1, 8'hFD, "R8");
        pulse(2); expect_port(2, 5'h11, "R9");
        pulse(1); expect_port(2, 5'h19, "R9");
        expect_port(1, 0, "R9");
        ctl_write(5'h19); expect_port(2, 5'h19, "R9");
        ctl_write(5'h11); expect_port(2, 5'h11, "R9");

        // R10 set beats clear
        dat_write(8'hFF);
        pre_tick = 1'b1; ctl_we = 1'b1; ctl_wdata = 5'h11;
        @(negedge clk);
        pre_tick = 1'b0; ctl_we = 1'b0;
        expect_port(2, 5'h19, "R10");
        ctl_write(5'h11);

        // R11 load wins over a tick
        pre_tick = 1'b1; dat_we = 1'b1; dat_wdata = 8'h40;
        @(negedge clk);
        pre_tick = 1'b0; dat_we = 1'b0;
        expect_port(1, 8'h40, "R11");
        pulse(1); expect_port(1, 8'h41, "R11");

        // R8 compare side, then R4/R5 waveform
        ctl_write(5'h10);
        dat_write(8'd4); expect_port(1, 4, "R8");
        ctl_write(5'h15);
        dat_write(8'hFF); expect_port(0, 0, "R4");
        pulse(1);   expect_port(0, 1, "R4");
        pulse(3);   expect_port(0, 1, "R5");
        pulse(1);   expect_port(0, 0, "R5");
        pulse(251); expect_port(0, 0, "R5");
        expect_port(1, 8'hFF, "R5");
        pulse(1);   expect_port(0, 1, "R4");

        // R3 output enable gating
        ctl_write(5'h11); expect_port(0, 0, "R3");
        ctl_write(5'h15); expect_port(0, 1, "R3");

        // R6 zero compare
        ctl_write(5'h14);
        dat_write(8'd0);
        ctl_write(5'h15); expect_port(0, 0, "R6");
        pulse(255); expect_port(0, 0, "R6");
        pulse(1);   expect_port(0, 0, "R6");
        expect_port(1, 0, "R6");
        pulse(3);   expect_port(0, 0, "R6");

        // R7 DC mode
        ctl_write(5'h17); expect_port(0, 1, "R7");
        ctl_write(5'h13); expect_port(0, 0, "R7");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule